// File: doc/BRIEF.md
# CAN Error Counter and Fault Confinement Tracker

This block keeps the transmit and receive error counters of a CAN controller and derives the fault-confinement conditions from them. The protocol engine reports each bus error as a one-cycle event with its direction, error kind and frame segment code. It also reports each successful frame per direction and each loss of arbitration with the bit position at which it happened. The block updates the counters and keeps three conditions: the warning level, error passive and bus off. It raises one-cycle change events that an interrupt unit can mask and latch.

Software reads two words. The counter word holds both counts. The status word holds the captured kind, direction and segment of the last bus error, the last arbitration-lost position, and the bus-off and warning flags. While the controller is held in configuration mode, software may program the warning limit and may clear both counters by writing zero to the counter word. Recovery from bus off beyond that clear belongs to another block.

Top module: `can_err_confine`

## Requirements
- R1: After reset, the counter word and the status word read 0, and warn_evt, passive_evt, err_passive and bus_off are 0.
- R2: A transmit error (err_evt with err_dir=0) adds 8 to the transmit count. A receive error (err_dir=1) adds 1 to the receive count, and the receive count saturates at 255.
- R3: ok_tx and ok_rx each lower their own count by 1, and neither count goes below 0. If an error and a success for the same direction arrive in the same cycle, the error applies and the success is dropped. Events for different directions in one cycle both apply.
- R4: The counter word carries the transmit count in bits 7:0 and the receive count in bits 23:16. All of its other bits read 0.
- R5: Status bit 6 (warning) is 1 while either count is at or above the warning limit. The limit is 96 after reset. A write to lim_wdata takes effect only while cfg_hold is 1.
- R6: warn_evt is high for exactly the one cycle in which status bit 6 changes value, in either direction.
- R7: err_passive is 1 while either count exceeds 127. passive_evt is high for the one cycle in which err_passive changes.
- R8: A transmit error that would take the transmit count above 255 sets bus_off (status bit 7) and leaves the transmit count at 255. While bus_off is 1, both counts ignore all error and success events.
- R9: A write of zero to the counter word while cfg_hold is 1 clears both counts and bus_off. A write of a non-zero value, or any write while cfg_hold is 0, leaves the counts unchanged.
- R10: Each err_evt captures err_kind into status bits 23:22 (0 bit, 1 form, 2 stuff, 3 other), err_dir into bit 21 (0 transmit, 1 receive) and err_seg into bits 20:16. These fields keep their values until the next err_evt.
- R11: Each arb_lost captures arb_pos into status bits 12:8. This field keeps its value until the next arb_lost and does not affect the error fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hold | input | 1 | Controller held in configuration mode |
| cnt_wr | input | 1 | Write strobe for the counter word |
| cnt_wdata | input | 32 | Data written to the counter word |
| lim_wr | input | 1 | Write strobe for the warning limit |
| lim_wdata | input | 8 | New warning limit |
| err_evt | input | 1 | Bus error seen by the protocol engine |
| err_dir | input | 1 | Direction of the error, 0 transmit, 1 receive |
| err_kind | input | 2 | Error kind code |
| err_seg | input | 5 | Frame segment code at the error |
| ok_tx | input | 1 | Frame transmitted successfully |
| ok_rx | input | 1 | Frame received successfully |
| arb_lost | input | 1 | Arbitration lost |
| arb_pos | input | 5 | Bit position at which arbitration was lost |
| cnt_word | output | 32 | Packed counter word |
| stat_word | output | 32 | Status word with captures and flags |
| warn_evt | output | 1 | Warning condition changed |
| passive_evt | output | 1 | Error-passive condition changed |
| err_passive | output | 1 | Error-passive condition |
| bus_off | output | 1 | Bus-off condition |

## Verification
An error and a success can arrive in the same cycle. They may target the same counter, where the error must win, or opposite counters, where both must apply. The stimulus table drives both combinations from known counts and compares the counter word one cycle later. A second overlap happens when a single counter update crosses a threshold: the flag and its change event must appear in the same cycle. The directed tests check this at the warning crossing, at passive entry and exit, and at a clear that drops both flags together.

// File: rtl/can_ecf_pkg.sv
package can_ecf_pkg;
  localparam int CNT_W  = 8;
  localparam int SEG_W  = 5;
  localparam int POS_W  = 5;
  localparam int KIND_W = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              dir;
    logic [SEG_W-1:0]  seg;
  } err_cap_t;

  // widened sum so the caller sees the carry out of the counter
  function automatic logic [CNT_W:0] widen_add(cnt_t v, cnt_t step);
    return {1'b0, v} + {1'b0, step};
  endfunction

  // limit a widened sum to the counter range
  function automatic cnt_t clip_sum(logic [CNT_W:0] s);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  // decrement that stops at zero
  function automatic cnt_t dec_floor(cnt_t v);
    return (v == '0) ? v : v - cnt_t'(1);
  endfunction

  function automatic logic at_or_above(cnt_t v, cnt_t lim);
    return v >= lim;
  endfunction
endpackage

// File: rtl/ecf_lane.sv
module ecf_lane
  import can_ecf_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic freeze,
  input  logic hit,
  input  logic ok,
  output cnt_t cnt,
  output cnt_t cnt_nxt,
  output logic carry_nxt
);
  localparam cnt_t STEP_C = cnt_t'(STEP);

  logic [CNT_W:0] sum;

  always_comb begin
    sum       = widen_add(cnt, STEP_C);
    cnt_nxt   = cnt;
    carry_nxt = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
    end else if (!freeze) begin
      if (hit) begin
        cnt_nxt   = clip_sum(sum);
        carry_nxt = sum[CNT_W];
      end else if (ok) begin
        cnt_nxt = dec_floor(cnt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/ecf_flags.sv
module ecf_flags
  import can_ecf_pkg::*;
#(
  parameter int WARN_DEF   = 96,
  parameter int PASSIVE_TH = 127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_hold,
  input  logic       lim_wr,
  input  logic [7:0] lim_wdata,
  input  cnt_t       tx_nxt,
  input  cnt_t       rx_nxt,
  output logic       warn,
  output logic       passive,
  output logic       warn_evt,
  output logic       passive_evt
);
  localparam cnt_t WARN_RST = cnt_t'(WARN_DEF);
  localparam cnt_t PAS_C    = cnt_t'(PASSIVE_TH);

  cnt_t lim, lim_nxt;
  logic warn_nxt, pas_nxt;

  always_comb begin
    lim_nxt  = (lim_wr && cfg_hold) ? cnt_t'(lim_wdata) : lim;
    warn_nxt = at_or_above(tx_nxt, lim_nxt) || at_or_above(rx_nxt, lim_nxt);
    pas_nxt  = (tx_nxt > PAS_C) || (rx_nxt > PAS_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim         <= WARN_RST;
      warn        <= 1'b0;
      passive     <= 1'b0;
      warn_evt    <= 1'b0;
      passive_evt <= 1'b0;
    end else begin
      lim         <= lim_nxt;
      warn        <= warn_nxt;
      passive     <= pas_nxt;
      warn_evt    <= warn_nxt ^ warn;
      passive_evt <= pas_nxt ^ passive;
    end
  end
endmodule

// File: rtl/ecf_capture.sv
module ecf_capture
  import can_ecf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  input  err_cap_t          err_in,
  input  logic              arb_lost,
  input  logic [POS_W-1:0]  arb_pos,
  output err_cap_t          err_q,
  output logic [POS_W-1:0]  pos_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      pos_q <= '0;
    end else begin
      if (err_evt)  err_q <= err_in;
      if (arb_lost) pos_q <= arb_pos;
    end
  end
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
  import can_ecf_pkg::*;
#(
  parameter int TX_STEP    = 8,
  parameter int RX_STEP    = 1,
  parameter int WARN_DEF   = 96,
  parameter int PASSIVE_TH = 127
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_hold,
  input  logic        cnt_wr,
  input  logic [31:0] cnt_wdata,
  input  logic        lim_wr,
  input  logic [7:0]  lim_wdata,
  input  logic        err_evt,
  input  logic        err_dir,
  input  logic [1:0]  err_kind,
  input  logic [4:0]  err_seg,
  input  logic        ok_tx,
  input  logic        ok_rx,
  input  logic        arb_lost,
  input  logic [4:0]  arb_pos,
  output logic [31:0] cnt_word,
  output logic [31:0] stat_word,
  output logic        warn_evt,
  output logic        passive_evt,
  output logic        err_passive,
  output logic        bus_off
);
  localparam int NLANE = 2;   // lane 0 transmit, lane 1 receive

  // named internal events, visible to the checker
  logic clr_hit;
  logic tx_hit, rx_hit;
  logic boff_q, boff_nxt;
  logic warn_q;

  cnt_t lane_cnt  [NLANE];
  cnt_t lane_nxt  [NLANE];
  logic lane_carry[NLANE];
  logic lane_hit  [NLANE];
  logic lane_ok   [NLANE];

  err_cap_t          cap_q;
  logic [POS_W-1:0]  pos_q;

  assign clr_hit = cnt_wr && cfg_hold && (cnt_wdata == 32'd0);
  assign tx_hit  = err_evt && !err_dir;
  assign rx_hit  = err_evt &&  err_dir;

  assign lane_hit[0] = tx_hit;
  assign lane_hit[1] = rx_hit;
  assign lane_ok[0]  = ok_tx;
  assign lane_ok[1]  = ok_rx;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int STEP_G = (g == 0) ? TX_STEP : RX_STEP;
    ecf_lane #(.STEP(STEP_G)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_hit),
      .freeze    (boff_q),
      .hit       (lane_hit[g]),
      .ok        (lane_ok[g]),
      .cnt       (lane_cnt[g]),
      .cnt_nxt   (lane_nxt[g]),
      .carry_nxt (lane_carry[g])
    );
  end

  // only a transmit overflow leads to bus off; receive saturates
  assign boff_nxt = clr_hit ? 1'b0 : (boff_q | lane_carry[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boff_q <= 1'b0;
    else        boff_q <= boff_nxt;
  end

  ecf_flags #(.WARN_DEF(WARN_DEF), .PASSIVE_TH(PASSIVE_TH)) flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_hold    (cfg_hold),
    .lim_wr      (lim_wr),
    .lim_wdata   (lim_wdata),
    .tx_nxt      (lane_nxt[0]),
    .rx_nxt      (lane_nxt[1]),
    .warn        (warn_q),
    .passive     (err_passive),
    .warn_evt    (warn_evt),
    .passive_evt (passive_evt)
  );

  ecf_capture cap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .err_in   ('{kind: err_kind, dir: err_dir, seg: err_seg}),
    .arb_lost (arb_lost),
    .arb_pos  (arb_pos),
    .err_q    (cap_q),
    .pos_q    (pos_q)
  );

  assign bus_off  = boff_q;
  assign cnt_word = {8'd0, lane_cnt[1], 8'd0, lane_cnt[0]};

  always_comb begin
    stat_word        = '0;
    stat_word[23:16] = cap_q;
    stat_word[12:8]  = pos_q;
    stat_word[7]     = boff_q;
    stat_word[6]     = warn_q;
  end
endmodule

// File: rtl/can_err_confine_chk.sv
module can_err_confine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_hold,
  input logic        cnt_wr,
  input logic [31:0] cnt_wdata,
  input logic        err_evt,
  input logic        err_dir,
  input logic        ok_tx,
  input logic [31:0] cnt_word,
  input logic [31:0] stat_word,
  input logic        warn_evt,
  input logic        passive_evt,
  input logic        err_passive,
  input logic        bus_off
);
  logic       clr_w;
  logic [7:0] tx_v;
  assign clr_w = cnt_wr && cfg_hold && (cnt_wdata == 32'd0);
  assign tx_v  = cnt_word[7:0];

  // R2
  tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !bus_off && err_evt && !err_dir && tx_v < 8'd248)
      |=> tx_v == $past(tx_v) + 8'd8);

  // R3
  tx_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !bus_off && ok_tx && !(err_evt && !err_dir) && tx_v != 8'd0)
      |=> tx_v == $past(tx_v) - 8'd1);

  // R6
  warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_evt |-> stat_word[6] != $past(stat_word[6]));

  // R7
  pas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    passive_evt |-> err_passive != $past(err_passive));

  // R8
  boff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && !clr_w) |=> (bus_off && $stable(cnt_word)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (cnt_word == 32'd0 && !bus_off));

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_evt |=> $stable(stat_word[23:16]));
endmodule

bind can_err_confine can_err_confine_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_hold    (cfg_hold),
  .cnt_wr      (cnt_wr),
  .cnt_wdata   (cnt_wdata),
  .err_evt     (err_evt),
  .err_dir     (err_dir),
  .ok_tx       (ok_tx),
  .cnt_word    (cnt_word),
  .stat_word   (stat_word),
  .warn_evt    (warn_evt),
  .passive_evt (passive_evt),
  .err_passive (err_passive),
  .bus_off     (bus_off)
);

// File: tb/can_err_confine_tb_top.sv
module can_err_confine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_hold = 1'b0, cnt_wr = 1'b0, lim_wr = 1'b0;
  logic [31:0] cnt_wdata = '0;
  logic [7:0]  lim_wdata = '0;
  logic        err_evt = 1'b0, err_dir = 1'b0, ok_tx = 1'b0, ok_rx = 1'b0;
  logic [1:0]  err_kind = '0;
  logic [4:0]  err_seg = '0, arb_pos = '0;
  logic        arb_lost = 1'b0;
  logic [31:0] cnt_word, stat_word;
  logic        warn_evt, passive_evt, err_passive, bus_off;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_confine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
    .err_evt(err_evt), .err_dir(err_dir), .err_kind(err_kind),
    .err_seg(err_seg), .ok_tx(ok_tx), .ok_rx(ok_rx), .arb_lost(arb_lost),
    .arb_pos(arb_pos), .cnt_word(cnt_word), .stat_word(stat_word),
    .warn_evt(warn_evt), .passive_evt(passive_evt),
    .err_passive(err_passive), .bus_off(bus_off)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
  endtask

  function automatic logic [31:0] cw(int tx, int rx);
    return (32'(rx) << 16) | 32'(tx);
  endfunction

  task automatic quiet();
    cfg_hold = 0; cnt_wr = 0; cnt_wdata = '0; lim_wr = 0; lim_wdata = '0;
    err_evt = 0; err_dir = 0; err_kind = '0; err_seg = '0;
    ok_tx = 0; ok_rx = 0; arb_lost = 0; arb_pos = '0;
  endtask

  // inputs are set just after a falling edge; one rising edge applies them
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tx_err(int n);
    for (int i = 0; i < n; i++) begin
      err_evt = 1; err_dir = 0; tick(); quiet();
    end
  endtask

  task automatic clear_cnt();
    cfg_hold = 1; cnt_wr = 1; cnt_wdata = 32'd0; tick();
  endtask

  // vector: {err, dir, ok_tx, ok_rx, tx_after, rx_after}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1000, 8'd8,  8'd0},   // R2 transmit error
    {4'b1100, 8'd8,  8'd1},   // R2 receive error
    {4'b0010, 8'd7,  8'd1},   // R3 transmit success
    {4'b0001, 8'd7,  8'd0},   // R3 receive success
    {4'b0001, 8'd7,  8'd0},   // R3 floor at zero
    {4'b1001, 8'd15, 8'd0},   // R3 tx error + rx success
    {4'b1110, 8'd14, 8'd1},   // R3 rx error + tx success
    {4'b1010, 8'd22, 8'd1}    // R3 same direction, error wins
  };

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) tick();
    // R1 reset state
    check("R1 cnt_word", cnt_word, 32'd0);
    check("R1 stat_word", stat_word, 32'd0);
    check("R1 flags", {28'd0, warn_evt, passive_evt, err_passive, bus_off}, 32'd0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) begin
      err_evt = VEC[v][19]; err_dir = VEC[v][18];
      ok_tx = VEC[v][17]; ok_rx = VEC[v][16];
      tick();
      check($sformatf("R3 R4 vector %0d", v), cnt_word,
            cw(int'(VEC[v][15:8]), int'(VEC[v][7:0])));
      quiet();
    end

    // R9 ignored clears
    cnt_wr = 1; cnt_wdata = 0; tick(); quiet();
    check("R9 clear outside cfg ignored", cnt_word, cw(22, 1));
    cfg_hold = 1; cnt_wr = 1; cnt_wdata = 32'd5; tick(); quiet();
    check("R9 nonzero write ignored", cnt_word, cw(22, 1));

    // R5 limit programming (rx=1)
    lim_wr = 1; lim_wdata = 8'd1; tick(); quiet();
    check("R5 limit write outside cfg ignored", {31'd0, stat_word[6]}, 32'd0);
    cfg_hold = 1; lim_wr = 1; lim_wdata = 8'd1; tick(); quiet();
    check("R5 warn with limit 1", {31'd0, stat_word[6]}, 32'd1);
    check("R6 warn_evt rise on limit", {31'd0, warn_evt}, 32'd1);
    tick();
    check("R6 warn_evt one cycle", {31'd0, warn_evt}, 32'd0);
    cfg_hold = 1; lim_wr = 1; lim_wdata = 8'd96; tick(); quiet();
    check("R6 warn_evt fall", {stat_word[6], warn_evt}, 32'd1);

    clear_cnt(); quiet();
    check("R9 clear in cfg", cnt_word, 32'd0);

    // R5 R6 warning crossing at 96
    tx_err(11);
    check("R5 below limit", {cnt_word[7:0], 7'd0, stat_word[6]}, {8'd88, 8'd0});
    err_evt = 1; tick(); quiet();
    check("R5 R6 at limit", {cnt_word[7:0], 6'd0, stat_word[6], warn_evt},
          {8'd96, 6'd0, 2'b11});

    // R7 passive entry and exit
    tx_err(3);
    check("R7 not passive at 120", {31'd0, err_passive}, 32'd0);
    err_evt = 1; tick(); quiet();
    check("R7 passive entry", {cnt_word[7:0], 6'd0, err_passive, passive_evt},
          {8'd128, 6'd0, 2'b11});
    ok_tx = 1; tick(); quiet();
    check("R7 passive exit", {cnt_word[7:0], 6'd0, err_passive, passive_evt},
          {8'd127, 6'd0, 2'b01});

    // R8 bus off
    tx_err(16);
    check("R8 at 255 not off", {cnt_word[7:0], 7'd0, bus_off}, {8'd255, 8'd0});
    err_evt = 1; tick(); quiet();
    check("R8 bus off entry", {cnt_word[7:0], 7'd0, stat_word[7]}, {8'd255, 8'd1});
    err_evt = 1; err_dir = 1; ok_tx = 1; tick(); quiet();
    check("R8 frozen counts", cnt_word, cw(255, 0));
    ok_tx = 1; ok_rx = 1; tick(); quiet();
    check("R8 frozen on success", cnt_word, cw(255, 0));

    // R9 clear leaves bus off, both flags drop with events
    clear_cnt(); quiet();
    check("R9 clear from bus off",
          {cnt_word[23:0], 2'd0, bus_off, err_passive, stat_word[6], passive_evt, warn_evt, 1'b0},
          {24'd0, 8'b00000110});

    // R10 R11 captures
    err_evt = 1; err_dir = 1; err_kind = 2'd2; err_seg = 5'h0A; tick(); quiet();
    check("R10 capture stuff rx data", stat_word, 32'h00AA_0000);
    arb_lost = 1; arb_pos = 5'd17; tick(); quiet();
    check("R11 arb position", stat_word, 32'h00AA_1100);
    tick();
    check("R10 R11 held", stat_word, 32'h00AA_1100);
    err_evt = 1; err_dir = 0; err_kind = 2'd1; err_seg = 5'h19; tick(); quiet();
    check("R10 capture form tx ack", stat_word, 32'h0059_1100);
    check("R2 counts after captures", cnt_word, cw(8, 1));

    // R2 receive saturation
    for (int i = 0; i < 256; i++) begin
      err_evt = 1; err_dir = 1; tick(); quiet();
    end
    check("R2 rx saturates", cnt_word, cw(8, 255));
    check("R7 passive from rx", {30'd0, err_passive, bus_off}, 32'd2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule